// File: doc/BRIEF.md
# Packet Pacing Scheduler for a Video Packetizer

This block decides when a downstream packet builder may begin each packet on a gigabit Ethernet transmit path clocked at 125 MHz. It issues a one-cycle start strobe, waits for the builder's done strobe, and then holds off for an idle gap before the next start. The gap length is counted in clock cycles. It comes from a six-bit switch code, so an operator can slow the stream or speed it up while it runs. This keeps a receiving host from dropping packets.

Each video frame is sent as a fixed run of packets. The block numbers them and exposes the current number so the builder can use it as a sequence number and line offset. It raises a frame-end pulse on the done strobe of the last packet. A source-select switch picks the payload, either the cycling colour pattern or the stored image. That choice is sampled once per packet, so it never changes while a packet is being built. One more switch input is reserved and ignored.

Top module: `pkt_pacer`

## Requirements
- R1: While rst_n is low at a clock edge, start_o, frame_end_o and pkt_idx_o are 0. In the first cycle after the first edge that samples rst_n high, start_o is 1.
- R2: start_o is high for exactly one cycle. After it, no further start_o occurs until done_i has been seen high, however long that takes.
- R3: Let G be the gap for the switch code. If done_i is high in a cycle while a packet is awaited, start_o is next high G+1 cycles later, which leaves exactly G idle cycles. When dly_sw[5:3] is 0, G = 3000 − 375·dly_sw[2:0], so code 0 gives 3000 and code 7 gives 375.
- R4: When dly_sw[2:0] is 0 and m = dly_sw[5:3] is 1 to 7, G = 3000 + 2500·m, which spans 5500 up to 20500.
- R5: When both switch groups are nonzero, the high group alone sets G and dly_sw[2:0] is ignored.
- R6: Switches pass through two flops, and G is latched on the done_i cycle. A switch change made during a gap leaves that gap's length unchanged and applies to the next gap.
- R7: pkt_idx_o starts at 0, increments on each accepted done_i, and wraps from 101 to 0. A frame is 102 packets.
- R8: frame_end_o is high in exactly the cycle in which done_i is accepted for packet 101, and never otherwise.
- R9: done_i pulses outside the wait for a packet, for example during a gap, change neither pkt_idx_o nor the gap length.
- R10: src_sel_o (0 = colour pattern, 1 = stored image) takes the synchronized src_sw value when start_o is issued. It holds that value until the next start_o.
- R11: spare_sw has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dly_sw | input | 6 | Gap select: [2:0] shortens, [5:3] lengthens |
| src_sw | input | 1 | Payload source switch |
| spare_sw | input | 1 | Reserved switch, ignored |
| done_i | input | 1 | Packet builder finished the current packet |
| start_o | output | 1 | One-cycle start of the next packet |
| frame_end_o | output | 1 | Pulse with the done of the last packet in a frame |
| pkt_idx_o | output | 7 | Number of the current packet within its frame |
| src_sel_o | output | 1 | Payload source for the current packet |

## Verification
The hardest situation to reach from the ports is the frame wrap. Packet 101 only arrives after more than a hundred complete start/done/gap rounds. The bench sets the shortest gap code and then runs directed rounds until the index wraps, checking frame_end_o on every done. Gap latching and ignored done pulses are reached from inside a single gap. The bench changes the switches, or pulses done_i, at a fixed cycle count into that gap, then measures the length of the gap to the cycle.

// File: rtl/pacer_pkg.sv
// Shared types for the packet pacing scheduler.
// Assumes: single clock domain, one package per scheduler build.
package pacer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } pace_state_t;
endpackage

// File: rtl/pacer_sync.sv
// Two-flop synchronizer for a group of slow switch inputs.
// Assumes: inputs change rarely; bits are not required to be coherent.
module pacer_sync #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/pacer_gap_decode.sv
// Turns the split switch code into a gap length in cycles.
// Assumes BASE_GAP > SHORT_STEP * (2**GRP_W - 1), so the result stays positive.
module pacer_gap_decode #(
    parameter int GRP_W      = 3,
    parameter int BASE_GAP   = 3000,
    parameter int SHORT_STEP = 375,
    parameter int LONG_STEP  = 2500,
    parameter int CNT_W      = 15
) (
    input  logic [2*GRP_W-1:0] code,
    output logic [CNT_W-1:0]   gap_len
);
    logic [GRP_W-1:0] lo_grp;
    logic [GRP_W-1:0] hi_grp;

    assign lo_grp = code[GRP_W-1:0];
    assign hi_grp = code[2*GRP_W-1:GRP_W];

    // The lengthening group, when nonzero, overrides the shortening group.
    always_comb begin
        if (hi_grp != '0)
            gap_len = CNT_W'(BASE_GAP) + CNT_W'(LONG_STEP) * CNT_W'(hi_grp);
        else
            gap_len = CNT_W'(BASE_GAP) - CNT_W'(SHORT_STEP) * CNT_W'(lo_grp);
    end
endmodule

// File: rtl/pacer_gap_cnt.sv
// Down-counter for the idle gap: loads length-1, flags expiry at zero.
// Assumes load_len >= 1.
module pacer_gap_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a new gap, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pkt_pacer.sv
// Packet pacing scheduler: start strobe, wait for done, switch-selected idle
// gap, packet and frame numbering, and a per-packet payload source select.
// Assumes: done_i is a one-cycle pulse from the packet builder; switches
// are asynchronous and slow.
module pkt_pacer
    import pacer_pkg::*;
#(
    parameter int  GRP_W          = 3,
    parameter int  BASE_GAP       = 3000,
    parameter int  SHORT_STEP     = 375,
    parameter int  LONG_STEP      = 2500,
    parameter int  PKTS_PER_FRAME = 102,
    localparam int IDX_W          = $clog2(PKTS_PER_FRAME),
    localparam int SW_W           = 2 * GRP_W,
    localparam int MAX_GAP        = BASE_GAP + LONG_STEP * ((1 << GRP_W) - 1),
    localparam int CNT_W          = $clog2(MAX_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW_W-1:0]  dly_sw,
    input  logic             src_sw,
    input  logic             spare_sw,
    input  logic             done_i,
    output logic             start_o,
    output logic             frame_end_o,
    output logic [IDX_W-1:0] pkt_idx_o,
    output logic             src_sel_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKTS_PER_FRAME - 1);

    logic [SW_W-1:0]  dly_s;
    logic             src_s;
    logic [CNT_W-1:0] gap_len;
    logic             gap_expired;
    logic             accept_done;
    logic             enter_start;
    logic             unused_spare;
    pace_state_t      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             src_q;

    assign unused_spare = spare_sw;

    pacer_sync #(.WIDTH(SW_W + 1)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({src_sw, dly_sw}),
        .d_sync ({src_s, dly_s})
    );

    pacer_gap_decode #(
        .GRP_W     (GRP_W),
        .BASE_GAP  (BASE_GAP),
        .SHORT_STEP(SHORT_STEP),
        .LONG_STEP (LONG_STEP),
        .CNT_W     (CNT_W)
    ) u_dec (
        .code   (dly_s),
        .gap_len(gap_len)
    );

    pacer_gap_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept_done),
        .load_len(gap_len),
        .expired (gap_expired)
    );

    assign accept_done = (state_q == ST_WAIT) && done_i;
    assign enter_start = (state_q == ST_IDLE) || ((state_q == ST_GAP) && gap_expired);

    // Next-state selection for the pacing sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_START;
            ST_START: state_d = ST_WAIT;
            ST_WAIT:  if (done_i) state_d = ST_GAP;
            ST_GAP:   if (gap_expired) state_d = ST_START;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Packet number: advance on each accepted done, wrap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (accept_done)
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end

    // Payload source: sampled once, as the packet start is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)           src_q <= 1'b0;
        else if (enter_start) src_q <= src_s;
    end

    assign start_o     = (state_q == ST_START);
    assign frame_end_o = accept_done && (idx_q == LAST_IDX);
    assign pkt_idx_o   = idx_q;
    assign src_sel_o   = src_q;
endmodule

// File: rtl/pkt_pacer_chk.sv
// Port-level properties of the packet pacing scheduler, bound to every instance.
module pkt_pacer_chk #(
    parameter int  PKTS_PER_FRAME = 102,
    localparam int IDX_W          = $clog2(PKTS_PER_FRAME)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done_i,
    input logic             start_o,
    input logic             frame_end_o,
    input logic [IDX_W-1:0] pkt_idx_o,
    input logic             src_sel_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKTS_PER_FRAME - 1);

    a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_idx_o <= LAST_IDX);

    a_r7_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (pkt_idx_o == '0));

    a_r9_idx_holds_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(pkt_idx_o));

    a_r8_frame_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> (done_i && pkt_idx_o == LAST_IDX));

    a_r10_src_changes_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_sel_o) |-> start_o);
endmodule

bind pkt_pacer pkt_pacer_chk #(.PKTS_PER_FRAME(PKTS_PER_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done_i),
    .start_o    (start_o),
    .frame_end_o(frame_end_o),
    .pkt_idx_o  (pkt_idx_o),
    .src_sel_o  (src_sel_o)
);

// File: tb/sim_pkt_pacer.sv
`timescale 1ns/1ps
module sim_pkt_pacer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] dly_sw = '0;
    logic       src_sw = 1'b0;
    logic       spare_sw = 1'b0;
    logic       done_i = 1'b0;
    logic       start_o;
    logic       frame_end_o;
    logic [6:0] pkt_idx_o;
    logic       src_sel_o;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_idx  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    pkt_pacer u0 (
        .clk(clk), .rst_n(rst_n), .dly_sw(dly_sw), .src_sw(src_sw),
        .spare_sw(spare_sw), .done_i(done_i), .start_o(start_o),
        .frame_end_o(frame_end_o), .pkt_idx_o(pkt_idx_o), .src_sel_o(src_sel_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Set switches and let them cross the synchronizer.
    task automatic set_sw(input logic [5:0] code);
        dly_sw = code;
        repeat (4) @(negedge clk);
    endtask

    // Finish the awaited packet and measure the gap until the next start.
    task automatic send_done(input int gap, input string req, input bit inj_done,
                             input int new_sw);
        int n;
        @(negedge clk);
        done_i = 1'b1;
        #1;
        check(frame_end_o == (exp_idx == 101), "R8 frame_end", frame_end_o, exp_idx == 101);
        @(negedge clk);
        done_i = 1'b0;
        exp_idx = (exp_idx == 101) ? 0 : exp_idx + 1;
        check(pkt_idx_o == exp_idx, "R7 index", pkt_idx_o, exp_idx);
        n = 1;
        while (!start_o && n < 30000) begin
            if (inj_done && n == 5) done_i = 1'b1;
            if (new_sw >= 0 && n == 10) dly_sw = 6'(new_sw);
            @(negedge clk);
            n++;
            if (inj_done && n == 6) begin
                done_i = 1'b0;
                check(pkt_idx_o == exp_idx, "R9 index unchanged", pkt_idx_o, exp_idx);
            end
        end
        check(n == gap + 1, req, n, gap + 1);
    endtask

    task automatic t_reset;
        check(start_o == 0 && frame_end_o == 0, "R1 strobes in reset", start_o, 0);
        check(pkt_idx_o == 0, "R1 index in reset", pkt_idx_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_o == 1, "R1 first start", start_o, 1);
        check(src_sel_o == 0, "R10 pattern source", src_sel_o, 0);
    endtask

    task automatic t_hold;
        int seen = 0;
        repeat (50) begin
            @(negedge clk);
            if (start_o) seen++;
        end
        check(seen == 0, "R2 no start without done", seen, 0);
        check(pkt_idx_o == 0, "R2 index held", pkt_idx_o, 0);
    endtask

    task automatic t_short_codes;
        set_sw(6'o00); send_done(3000, "R3 code 0 gap", 0, -1);
        set_sw(6'o03); send_done(1875, "R3 code 3 gap", 0, -1);
        set_sw(6'o07); send_done(375,  "R3 code 7 gap", 0, -1);
    endtask

    task automatic t_long_codes;
        set_sw(6'o10); send_done(5500,  "R4 m=1 gap", 0, -1);
        set_sw(6'o70); send_done(20500, "R4 m=7 gap", 0, -1);
    endtask

    task automatic t_priority;
        set_sw(6'o25); send_done(8000, "R5 high group wins", 0, -1);
    endtask

    task automatic t_latch;
        set_sw(6'o07);
        send_done(375, "R6 gap kept after switch change", 0, 0);
        repeat (3) @(negedge clk);
        send_done(3000, "R6 new code on next gap", 0, -1);
    endtask

    task automatic t_ignored_done;
        set_sw(6'o03);
        send_done(1875, "R9 gap kept with stray done", 1, -1);
    endtask

    task automatic t_spare;
        spare_sw = 1'b1;
        set_sw(6'o03);
        send_done(1875, "R11 spare switch ignored", 0, -1);
        spare_sw = 1'b0;
    endtask

    task automatic t_source;
        src_sw = 1'b1;
        repeat (6) @(negedge clk);
        check(src_sel_o == 0, "R10 held mid packet", src_sel_o, 0);
        set_sw(6'o07);
        send_done(375, "R10 gap", 0, -1);
        check(src_sel_o == 1, "R10 image source at start", src_sel_o, 1);
    endtask

    task automatic t_frame;
        int guard = 0;
        set_sw(6'o07);
        while (exp_idx != 101 && guard < 200) begin
            send_done(375, "R7 frame gap", 0, -1);
            guard++;
        end
        check(pkt_idx_o == 101, "R7 reached last packet", pkt_idx_o, 101);
        send_done(375, "R8 gap after frame end", 0, -1);
        check(pkt_idx_o == 0, "R7 wrap to 0", pkt_idx_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hold();
        t_short_codes();
        t_long_codes();
        t_priority();
        t_latch();
        t_ignored_done();
        t_spare();
        t_source();
        t_frame();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            check(0, "watchdog", cycles, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule